// File: doc/BRIEF.md
# PHY Configuration Replay Sequencer

After a PHY reset, this block copies a list of PHY register settings from a word-addressed nonvolatile memory into the PHY. A one-cycle start pulse begins a run. The sequencer then checks a software-configuration enable bit. If the bit is set, it waits for the LAN initialisation to report that it is finished, and then issues a one-cycle pulse that clears that indication. A lock flag or an empty region ends the run at this point.

When neither condition applies, the block reads the region one entry at a time. Each entry is two words: a data word followed by a register-address word. Entries that target the page-select register are not sent to the PHY; their data is stored as the current page. Every other entry goes out as a single write request, and its address is the entry address ORed with that page. There is never more than one memory read or PHY write outstanding, and each one completes on its acknowledge.

The state machine has these states:

- IDLE: waiting for start.
- CHK_EN: tests the enable bit. Goes to POLL when the bit is set, otherwise to FIN.
- POLL: samples the init-done flag on every tick of the poll interval. Goes to CLR when the flag is seen or when the poll limit is reached.
- CLR: drives the clear pulse, then goes to CHK_CFG.
- CHK_CFG: latches the pointer and size and resets the page. Goes to FIN when locked or empty, otherwise to RD_DATA.
- RD_DATA: reads the data word. Goes to RD_ADDR on acknowledge, or to FAIL on error.
- RD_ADDR: reads the address word. Goes to DECIDE on acknowledge, or to FAIL on error.
- DECIDE: a page entry is absorbed and goes to NEXT; any other entry goes to WRITE.
- WRITE: goes to NEXT on acknowledge, or to FAIL on error.
- NEXT: goes to FIN after the last entry, otherwise back to RD_DATA.
- FIN: sets done and returns to IDLE.
- FAIL: sets done and error and returns to IDLE.

Top module: `phy_cfg_loader`

## Requirements
- R1: With `sw_cfg_en_i` low at start, the run ends with `done_o` high, no clear pulse, no memory read and no PHY write.
- R2: `init_done_i` is sampled once every POLL_INTERVAL cycles. After POLL_LIMIT samples that all found it low, the run still continues and `timeout_o` is set. If the flag is seen earlier, `timeout_o` stays low.
- R3: Once the wait is over, `clr_init_done_o` is high for exactly one cycle.
- R4: If `lcd_wr_en_i` is high or `cfg_size_i` is zero after the wait, the run ends with `done_o` and no memory read or PHY write.
- R5: The pointer is in dwords, so the first word read is at `cfg_base_dw_i` shifted left by one. Entry i is read as data at word base+2i and then address at base+2i+1, in increasing order.
- R6: An entry whose address word equals PAGE_SEL_ADDR (default 0x001F) writes nothing to the PHY. Its data word becomes the page.
- R7: Any other entry is written as data to (address OR page). The page is zero at the start of each run and keeps its value across later entries.
- R8: A memory read acknowledged with `nvm_rd_err_i` ends the run at once with `error_o` and `done_o` set, and no further request is made.
- R9: A PHY write acknowledged with `phy_wr_err_i` ends the run at once with `error_o` and `done_o` set, and no further request is made.
- R10: The memory read request and the PHY write request are never high together. Each request, together with its address and data, holds steady until it is acknowledged.
- R11: A start pulse while `busy_o` is high has no effect. An accepted start clears `done_o`, `timeout_o` and `error_o`, and `done_o` is never high while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle run request |
| sw_cfg_en_i | input | 1 | Software configuration enable |
| init_done_i | input | 1 | LAN initialisation finished |
| lcd_wr_en_i | input | 1 | Hardware already owns PHY configuration (lock) |
| cfg_size_i | input | SIZE_W | Number of entries in the region |
| cfg_base_dw_i | input | PTR_W | Region start, in dwords |
| nvm_rd_req_o | output | 1 | Memory read request |
| nvm_rd_addr_o | output | NVM_AW | Word address of the read |
| nvm_rd_ack_i | input | 1 | Read completes with data |
| nvm_rd_data_i | input | 16 | Read data |
| nvm_rd_err_i | input | 1 | Read failed, valid with ack |
| phy_wr_req_o | output | 1 | PHY register write request |
| phy_wr_addr_o | output | 16 | PHY register address including page |
| phy_wr_data_o | output | 16 | PHY register data |
| phy_wr_ack_i | input | 1 | Write completed |
| phy_wr_err_i | input | 1 | Write failed, valid with ack |
| clr_init_done_o | output | 1 | One-cycle clear of the init-done indication |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run ended, held until the next start |
| timeout_o | output | 1 | Last run gave up waiting for init-done |
| error_o | output | 1 | Last run was aborted by an error |

## Verification
The assertions check the handshake rules on every cycle:
- the two requests are never high together;
- each request stays up, with stable address and data, until it is acknowledged;
- the clear pulse lasts exactly one cycle;
- done never overlaps busy;
- both ports are silent while idle.

The directed scenarios are the only way to show the rest:
- the address arithmetic and the entry order;
- page absorption and the page reset between runs;
- the three early exits;
- the poll-limit timeout and how long it takes;
- the exact point at which each kind of error stops the sequence.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHK_EN,
        S_POLL,
        S_CLR,
        S_CHK_CFG,
        S_RD_DATA,
        S_RD_ADDR,
        S_DECIDE,
        S_WRITE,
        S_NEXT,
        S_FIN,
        S_FAIL
    } pcl_state_e;

endpackage

// File: rtl/pcl_poll_timer.sv
// Produces a sample strobe every INTERVAL cycles while run_i is high.
// The first strobe comes on the first cycle of the run. last_o marks the
// LIMIT-th strobe.
module pcl_poll_timer #(
    parameter int INTERVAL = 4,
    parameter int LIMIT    = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o,
    output logic last_o
);
    localparam int IW = $clog2(INTERVAL + 1);
    localparam int LW = $clog2(LIMIT + 1);

    logic [IW-1:0] gap_q;
    logic [LW-1:0] polls_q;

    assign tick_o = run_i && (gap_q == '0);
    assign last_o = tick_o && (polls_q == LW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (!run_i) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (tick_o) begin
            gap_q   <= IW'(INTERVAL - 1);
            polls_q <= polls_q + 1'b1;
        end else begin
            gap_q   <= gap_q - 1'b1;
        end
    end

endmodule

// File: rtl/pcl_addr_gen.sv
// Keeps the entry index and forms word addresses: (base<<1) + 2*idx + phase.
module pcl_addr_gen #(
    parameter int PTR_W  = 12,
    parameter int SIZE_W = 8,
    parameter int AW     = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              phase_i,
    input  logic [PTR_W-1:0]  base_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [AW-1:0]     addr_o,
    output logic              last_o
);
    logic [PTR_W-1:0]  base_q;
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            base_q <= base_i;
            size_q <= size_i;
            idx_q  <= '0;
        end else if (step_i) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign addr_o = {AW'(base_q), 1'b0} + {AW'(idx_q), 1'b0} + AW'(phase_i);
    assign last_o = (idx_q == size_q - SIZE_W'(1));

endmodule

// File: rtl/pcl_page_track.sv
// Holds the fetched entry words and the current page, and forms the PHY
// address by ORing the entry address with the page.
module pcl_page_track #(
    parameter int          W        = 16,
    parameter logic [15:0] PAGE_SEL = 16'h001F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         cap_data_i,
    input  logic         cap_addr_i,
    input  logic         absorb_i,
    input  logic [W-1:0] word_i,
    output logic         is_page_o,
    output logic [W-1:0] phy_addr_o,
    output logic [W-1:0] phy_data_o
);
    logic [W-1:0] data_q;
    logic [W-1:0] addr_q;
    logic [W-1:0] page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            addr_q <= '0;
            page_q <= '0;
        end else begin
            if (clear_i)    page_q <= '0;
            if (absorb_i)   page_q <= data_q;
            if (cap_data_i) data_q <= word_i;
            if (cap_addr_i) addr_q <= word_i;
        end
    end

    assign is_page_o  = (addr_q == W'(PAGE_SEL));
    assign phy_addr_o = addr_q | page_q;
    assign phy_data_o = data_q;

endmodule

// File: rtl/phy_cfg_loader.sv
module phy_cfg_loader
    import pcl_pkg::*;
#(
    parameter int          PTR_W         = 12,
    parameter int          SIZE_W        = 8,
    parameter int          POLL_INTERVAL = 4,
    parameter int          POLL_LIMIT    = 1500,
    parameter logic [15:0] PAGE_SEL_ADDR = 16'h001F,
    localparam int         NVM_AW        = ((PTR_W > SIZE_W) ? PTR_W : SIZE_W) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sw_cfg_en_i,
    input  logic              init_done_i,
    input  logic              lcd_wr_en_i,
    input  logic [SIZE_W-1:0] cfg_size_i,
    input  logic [PTR_W-1:0]  cfg_base_dw_i,
    output logic              nvm_rd_req_o,
    output logic [NVM_AW-1:0] nvm_rd_addr_o,
    input  logic              nvm_rd_ack_i,
    input  logic [15:0]       nvm_rd_data_i,
    input  logic              nvm_rd_err_i,
    output logic              phy_wr_req_o,
    output logic [15:0]       phy_wr_addr_o,
    output logic [15:0]       phy_wr_data_o,
    input  logic              phy_wr_ack_i,
    input  logic              phy_wr_err_i,
    output logic              clr_init_done_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              error_o
);
    pcl_state_e state_q, state_d;

    logic poll_tick, poll_last;
    logic ag_load, ag_step, ag_phase, ag_last;
    logic pt_cap_data, pt_cap_addr, pt_absorb, pt_is_page;
    logic done_q, timeout_q, error_q;
    logic start_ok, poll_gaveup;

    pcl_poll_timer #(
        .INTERVAL (POLL_INTERVAL),
        .LIMIT    (POLL_LIMIT)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == S_POLL),
        .tick_o (poll_tick),
        .last_o (poll_last)
    );

    pcl_addr_gen #(
        .PTR_W  (PTR_W),
        .SIZE_W (SIZE_W),
        .AW     (NVM_AW)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ag_load),
        .step_i  (ag_step),
        .phase_i (ag_phase),
        .base_i  (cfg_base_dw_i),
        .size_i  (cfg_size_i),
        .addr_o  (nvm_rd_addr_o),
        .last_o  (ag_last)
    );

    pcl_page_track #(
        .W        (WORD_W),
        .PAGE_SEL (PAGE_SEL_ADDR)
    ) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (ag_load),
        .cap_data_i (pt_cap_data),
        .cap_addr_i (pt_cap_addr),
        .absorb_i   (pt_absorb),
        .word_i     (nvm_rd_data_i),
        .is_page_o  (pt_is_page),
        .phy_addr_o (phy_wr_addr_o),
        .phy_data_o (phy_wr_data_o)
    );

    assign start_ok    = (state_q == S_IDLE) && start_i;
    assign poll_gaveup = (state_q == S_POLL) && poll_tick && !init_done_i && poll_last;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i) state_d = S_CHK_EN;
            S_CHK_EN:  state_d = sw_cfg_en_i ? S_POLL : S_FIN;
            S_POLL:    if (poll_tick && (init_done_i || poll_last)) state_d = S_CLR;
            S_CLR:     state_d = S_CHK_CFG;
            S_CHK_CFG: state_d = (lcd_wr_en_i || (cfg_size_i == '0)) ? S_FIN : S_RD_DATA;
            S_RD_DATA: if (nvm_rd_ack_i) state_d = nvm_rd_err_i ? S_FAIL : S_RD_ADDR;
            S_RD_ADDR: if (nvm_rd_ack_i) state_d = nvm_rd_err_i ? S_FAIL : S_DECIDE;
            S_DECIDE:  state_d = pt_is_page ? S_NEXT : S_WRITE;
            S_WRITE:   if (phy_wr_ack_i) state_d = phy_wr_err_i ? S_FAIL : S_NEXT;
            S_NEXT:    state_d = ag_last ? S_FIN : S_RD_DATA;
            S_FIN:     state_d = S_IDLE;
            S_FAIL:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // State register and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            done_q    <= 1'b0;
            timeout_q <= 1'b0;
            error_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                done_q    <= 1'b0;
                timeout_q <= 1'b0;
                error_q   <= 1'b0;
            end else begin
                if (state_q == S_FIN || state_q == S_FAIL) done_q <= 1'b1;
                if (state_q == S_FAIL) error_q <= 1'b1;
                if (poll_gaveup) timeout_q <= 1'b1;
            end
        end
    end

    // Outputs and datapath strobes decoded from the state
    always_comb begin
        nvm_rd_req_o    = 1'b0;
        phy_wr_req_o    = 1'b0;
        clr_init_done_o = 1'b0;
        ag_load         = 1'b0;
        ag_step         = 1'b0;
        ag_phase        = 1'b0;
        pt_cap_data     = 1'b0;
        pt_cap_addr     = 1'b0;
        pt_absorb       = 1'b0;
        unique case (state_q)
            S_CLR:     clr_init_done_o = 1'b1;
            S_CHK_CFG: ag_load = 1'b1;
            S_RD_DATA: begin
                nvm_rd_req_o = 1'b1;
                pt_cap_data  = nvm_rd_ack_i && !nvm_rd_err_i;
            end
            S_RD_ADDR: begin
                nvm_rd_req_o = 1'b1;
                ag_phase     = 1'b1;
                pt_cap_addr  = nvm_rd_ack_i && !nvm_rd_err_i;
            end
            S_DECIDE:  pt_absorb = pt_is_page;
            S_WRITE:   phy_wr_req_o = 1'b1;
            S_NEXT:    ag_step = !ag_last;
            default:   ;
        endcase
    end

    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = done_q;
    assign timeout_o = timeout_q;
    assign error_o   = error_q;

endmodule

// File: rtl/pcl_checker.sv
module pcl_checker #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          nvm_rd_req_o,
    input logic [AW-1:0] nvm_rd_addr_o,
    input logic          nvm_rd_ack_i,
    input logic          phy_wr_req_o,
    input logic [15:0]   phy_wr_addr_o,
    input logic [15:0]   phy_wr_data_o,
    input logic          phy_wr_ack_i,
    input logic          clr_init_done_o,
    input logic          busy_o,
    input logic          done_o
);
    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        !(nvm_rd_req_o && phy_wr_req_o));

    a_r10_nvm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_rd_req_o && !nvm_rd_ack_i) |=> (nvm_rd_req_o && $stable(nvm_rd_addr_o)));

    a_r10_phy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_wr_req_o && !phy_wr_ack_i) |=>
            (phy_wr_req_o && $stable(phy_wr_addr_o) && $stable(phy_wr_data_o)));

    a_r3_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        clr_init_done_o |=> !clr_init_done_o);

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!nvm_rd_req_o && !phy_wr_req_o && !clr_init_done_o));

endmodule

bind phy_cfg_loader pcl_checker #(.AW(NVM_AW)) u_pcl_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .nvm_rd_req_o    (nvm_rd_req_o),
    .nvm_rd_addr_o   (nvm_rd_addr_o),
    .nvm_rd_ack_i    (nvm_rd_ack_i),
    .phy_wr_req_o    (phy_wr_req_o),
    .phy_wr_addr_o   (phy_wr_addr_o),
    .phy_wr_data_o   (phy_wr_data_o),
    .phy_wr_ack_i    (phy_wr_ack_i),
    .clr_init_done_o (clr_init_done_o),
    .busy_o          (busy_o),
    .done_o          (done_o)
);

// File: tb/phy_cfg_loader_test.sv
module phy_cfg_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int INTERVAL   = 4;
    localparam int LIMIT      = 1500;
    localparam int AW         = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, sw_cfg_en_i = 1'b0, init_done_i = 1'b1, lcd_wr_en_i = 1'b0;
    logic [7:0]  cfg_size_i = '0;
    logic [11:0] cfg_base_dw_i = '0;
    logic        nvm_rd_req_o, phy_wr_req_o, clr_init_done_o, busy_o, done_o, timeout_o, error_o;
    logic [AW-1:0] nvm_rd_addr_o;
    logic        nvm_rd_ack_i = 1'b0, nvm_rd_err_i = 1'b0;
    logic [15:0] nvm_rd_data_i = '0;
    logic [15:0] phy_wr_addr_o, phy_wr_data_o;
    logic        phy_wr_ack_i = 1'b0, phy_wr_err_i = 1'b0;

    int checks = 0, fails = 0;
    int cyc = 0;
    logic [15:0] mem [0:63];
    int rd_n, rd_first, rd_last, wr_n, clr_n, clr_cyc;
    logic [15:0] wr_addr [0:15];
    logic [15:0] wr_data [0:15];
    int nvm_err_addr = -1, phy_err_idx = -1;

    phy_cfg_loader #(
        .PTR_W(12), .SIZE_W(8), .POLL_INTERVAL(INTERVAL), .POLL_LIMIT(LIMIT),
        .PAGE_SEL_ADDR(16'h001F)
    ) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cycle counter and clear-pulse monitor
    initial forever begin
        @(negedge clk);
        cyc++;
        if (clr_init_done_o) begin clr_n++; clr_cyc = cyc; end
    end

    // Memory responder: two cycles of latency, one-cycle ack
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (nvm_rd_ack_i) begin
                nvm_rd_ack_i = 1'b0; nvm_rd_err_i = 1'b0; lat = 0;
            end else if (nvm_rd_req_o) begin
                lat++;
                if (lat == 2) begin
                    nvm_rd_ack_i  = 1'b1;
                    nvm_rd_data_i = mem[nvm_rd_addr_o[5:0]];
                    nvm_rd_err_i  = (int'(nvm_rd_addr_o) == nvm_err_addr);
                    if (rd_n == 0) rd_first = int'(nvm_rd_addr_o);
                    rd_last = int'(nvm_rd_addr_o);
                    rd_n++;
                end
            end
        end
    end

    // PHY responder: records each write
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (phy_wr_ack_i) begin
                phy_wr_ack_i = 1'b0; phy_wr_err_i = 1'b0; lat = 0;
            end else if (phy_wr_req_o) begin
                lat++;
                if (lat == 3) begin
                    phy_wr_ack_i = 1'b1;
                    phy_wr_err_i = (wr_n == phy_err_idx);
                    if (wr_n < 16) begin
                        wr_addr[wr_n] = phy_wr_addr_o;
                        wr_data[wr_n] = phy_wr_data_o;
                    end
                    wr_n++;
                end
            end
        end
    end

    task automatic run_load(input bit en, input bit lcd, input int size, input int base,
                            output int start_cyc);
        rd_n = 0; wr_n = 0; clr_n = 0;
        sw_cfg_en_i = en; lcd_wr_en_i = lcd;
        cfg_size_i = 8'(size); cfg_base_dw_i = 12'(base);
        @(negedge clk); start_i = 1'b1; start_cyc = cyc;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 20000 && !done_o; i++) @(negedge clk);
        chk(done_o === 1'b1, "R11 run reaches done", int'(done_o), 1);
        chk(busy_o === 1'b0, "R11 idle after done", int'(busy_o), 0);
    endtask

    task automatic t_reset;
        chk(busy_o === 1'b0 && done_o === 1'b0 && nvm_rd_req_o === 1'b0 && phy_wr_req_o === 1'b0,
            "R10 reset state quiet", int'({busy_o, done_o, nvm_rd_req_o, phy_wr_req_o}), 0);
    endtask

    task automatic t_disabled;
        int sc;
        run_load(1'b0, 1'b0, 2, 16, sc);
        chk(clr_n == 0, "R1 no clear pulse when disabled", clr_n, 0);
        chk(rd_n == 0 && wr_n == 0, "R1 no traffic when disabled", rd_n + wr_n, 0);
    endtask

    task automatic t_locked;
        int sc;
        run_load(1'b1, 1'b1, 2, 16, sc);
        chk(clr_n == 1, "R3 one clear pulse", clr_n, 1);
        chk(rd_n == 0 && wr_n == 0, "R4 lock prevents traffic", rd_n + wr_n, 0);
        chk(timeout_o === 1'b0, "R2 no timeout with init done", int'(timeout_o), 0);
        run_load(1'b1, 1'b0, 0, 16, sc);
        chk(rd_n == 0 && wr_n == 0, "R4 empty region no traffic", rd_n + wr_n, 0);
        chk(clr_n == 1, "R3 clear pulse on empty run", clr_n, 1);
    endtask

    task automatic t_main;
        int sc;
        // Pointer 0x10 dwords: entries at words 0x20..0x27
        rd_n = 0; wr_n = 0; clr_n = 0;
        sw_cfg_en_i = 1'b1; lcd_wr_en_i = 1'b0; cfg_size_i = 8'd4; cfg_base_dw_i = 12'h010;
        @(negedge clk); start_i = 1'b1; sc = cyc;
        @(negedge clk); start_i = 1'b0;
        repeat (10) @(negedge clk);
        start_i = 1'b1; // while busy: must be ignored
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < 20000 && !done_o; i++) @(negedge clk);
        chk(done_o === 1'b1 && error_o === 1'b0, "R7 main run completes", int'(done_o), 1);
        chk(rd_n == 8, "R5 eight words read", rd_n, 8);
        chk(rd_first == 'h20, "R5 first read at pointer*2", rd_first, 'h20);
        chk(rd_last == 'h27, "R5 last read address", rd_last, 'h27);
        chk(wr_n == 3, "R6 page entry not written", wr_n, 3);
        chk(wr_addr[0] == 16'h0005 && wr_data[0] == 16'h1234, "R7 first write page 0",
            int'(wr_addr[0]), 'h5);
        chk(wr_addr[1] == 16'h0307 && wr_data[1] == 16'hABCD, "R6 page ORed into address",
            int'(wr_addr[1]), 'h307);
        chk(wr_addr[2] == 16'h0310 && wr_data[2] == 16'h5555, "R7 page persists",
            int'(wr_addr[2]), 'h310);
        repeat (3) @(negedge clk);
        chk(done_o === 1'b1 && busy_o === 1'b0, "R11 start while busy ignored", int'(busy_o), 0);
    endtask

    task automatic t_page_reset;
        int sc;
        run_load(1'b1, 1'b0, 1, 'h18, sc);
        chk(wr_n == 1 && wr_addr[0] == 16'h0005 && wr_data[0] == 16'h0042,
            "R7 page zero at new run", int'(wr_addr[0]), 'h5);
    endtask

    task automatic t_timeout;
        int sc, el;
        init_done_i = 1'b0;
        run_load(1'b1, 1'b0, 1, 'h18, sc);
        el = clr_cyc - sc;
        chk(timeout_o === 1'b1, "R2 timeout flag after poll limit", int'(timeout_o), 1);
        chk(el >= (LIMIT - 1) * INTERVAL && el <= LIMIT * INTERVAL + 8,
            "R2 wait length", el, (LIMIT - 1) * INTERVAL);
        chk(wr_n == 1, "R2 continues after timeout", wr_n, 1);
        chk(clr_n == 1, "R3 clear after timeout", clr_n, 1);
        init_done_i = 1'b1;
    endtask

    task automatic t_late_init;
        int sc;
        init_done_i = 1'b0;
        fork
            begin repeat (60) @(negedge clk); init_done_i = 1'b1; end
        join_none
        run_load(1'b1, 1'b0, 1, 'h18, sc);
        chk(timeout_o === 1'b0, "R2 no timeout when init done arrives", int'(timeout_o), 0);
        chk(clr_cyc - sc >= 55, "R2 waited for init done", clr_cyc - sc, 60);
    endtask

    task automatic t_nvm_err;
        int sc;
        nvm_err_addr = 'h23;
        run_load(1'b1, 1'b0, 4, 'h10, sc);
        chk(error_o === 1'b1, "R8 error flag on read error", int'(error_o), 1);
        chk(rd_n == 4 && wr_n == 1, "R8 sequence stops at read error", rd_n * 16 + wr_n, 'h41);
        nvm_err_addr = -1;
    endtask

    task automatic t_phy_err;
        int sc;
        phy_err_idx = 1;
        run_load(1'b1, 1'b0, 4, 'h10, sc);
        chk(error_o === 1'b1, "R9 error flag on write error", int'(error_o), 1);
        chk(rd_n == 6 && wr_n == 2, "R9 sequence stops at write error", rd_n * 16 + wr_n, 'h62);
        phy_err_idx = -1;
        run_load(1'b1, 1'b0, 1, 'h18, sc);
        chk(error_o === 1'b0 && timeout_o === 1'b0, "R11 flags cleared by new start",
            int'(error_o), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
        mem['h20] = 16'h1234; mem['h21] = 16'h0005;
        mem['h22] = 16'h0300; mem['h23] = 16'h001F;
        mem['h24] = 16'hABCD; mem['h25] = 16'h0007;
        mem['h26] = 16'h5555; mem['h27] = 16'h0010;
        mem['h30] = 16'h0042; mem['h31] = 16'h0005;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_locked();
        t_main();
        t_page_reset();
        t_timeout();
        t_late_init();
        t_nvm_err();
        t_phy_err();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule